// File: doc/BRIEF.md
# Conversion-Synchronous Serial ADC Reader

This block drives a 14-bit successive-approximation converter from the host side. One divided clock both paces the conversion and shifts out each result bit as soon as the converter resolves it. No separate burst clock is needed, and a result is ready the moment a conversion ends.

After the block leaves reset it holds the converter's reset line low for a short, fixed number of system cycles. It then runs the conversion clock through the calibration phase, and no conversion may begin until that phase is over. Calibration ends either after a fixed count of clock cycles or when the converter's end-of-conversion line goes low. A parameter picks which. A start request launches a conversion: chip-select and convert go low for exactly 20 conversion clocks, the data bits are shifted in, and the 14-bit result is presented with a one-cycle valid strobe. A start that arrives during calibration or during a conversion is held and served afterwards.

Top module: `adc_conv_reader`

## Requirements
- R1: While rst_ni is low, and after it rises, adc_rst_no stays low for RST_LEN system cycles. Throughout this time adc_cs_no and adc_conv_no are high, adc_clk_o is low, and valid_o and busy_o are low.
- R2: With CAL_BY_EOC=0, exactly CAL_CYCLES (14000) rising edges of adc_clk_o occur between the release of adc_rst_no and the first assertion of adc_cs_no.
- R3: With CAL_BY_EOC=1, adc_cs_no is first asserted only after eoc_i has gone low.
- R4: adc_clk_o spends HALF_DIV system cycles high and HALF_DIV system cycles low. It rests low outside calibration and conversion.
- R5: Each conversion has exactly CONV_CYCLES (20) rising edges of adc_clk_o while adc_cs_no is low. adc_cs_no goes high again between conversions.
- R6: The n-th conversion clock of a conversion carries slot n, counting from 1. Slots 1 to 4 are ignored. Slots 5 to 18 carry result bits 13 down to 0 in that order. Slots 19 and 20 are the two sub-bits and are dropped.
- R7: With SAMPLE_FALL=0, slot n is read at rising edge n of adc_clk_o. With SAMPLE_FALL=1, it is read at falling edge n. When dout_i changes just after falling edges, both settings return the same result.
- R8: valid_o is high for exactly one system cycle: the first cycle in which adc_cs_no is high again after the 20th falling edge. result_o holds its value until the next valid_o.
- R9: A start_i pulse during calibration or during a conversion is held. It launches one further conversion once the current phase ends.
- R10: busy_o rises in the cycle after start_i. If no start is held, it is low in the cycle in which valid_o is high.
- R11: adc_cs_no stays low for exactly CONV_CYCLES*2*HALF_DIV system cycles per conversion. That count never exceeds MAX_CONV_CYC (20 ms of system clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, one-cycle pulse |
| eoc_i | input | 1 | Converter end-of-conversion (low = done) |
| dout_i | input | 1 | Converter serial data |
| adc_rst_no | output | 1 | Converter reset, active low |
| adc_cs_no | output | 1 | Converter chip-select, active low |
| adc_conv_no | output | 1 | Converter convert command, active low |
| adc_clk_o | output | 1 | Combined conversion and data clock |
| result_o | output | DATA_W | Last conversion result |
| valid_o | output | 1 | One-cycle result strobe |
| busy_o | output | 1 | Request held or conversion in progress |

## Verification
The assertions assume that start_i is a synchronous pulse. In end-of-conversion mode they assume eoc_i is high from the converter reset until calibration ends. They also assume dout_i changes only after a falling edge of adc_clk_o, and that MAX_CONV_CYC matches the system clock rate. The bench builds its converter model on these terms: data moves 1 ns after each falling conversion-clock edge, end-of-conversion falls after the 14000th rising edge, and every request is a single clean cycle launched after a rising system edge.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_RST  = 2'd0,
    ST_CAL  = 2'd1,
    ST_IDLE = 2'd2,
    ST_CONV = 2'd3
  } seq_st_e;
endpackage

// File: rtl/adc_rd_clkgen.sv
module adc_rd_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          clk_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = run_i & at_end & ~clk_q;
  assign fall_o = run_i & at_end & clk_q;
  assign sclk_o = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (at_end) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R4
  clk_rest_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_i) |-> !sclk_o);
  // R4
  clk_toggle_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != $past(sclk_o)) |-> $past(run_i));
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int DATA_W      = 14,
  parameter int LEAD        = 4,
  parameter int SW          = 5,
  parameter bit SAMPLE_FALL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [SW-1:0]     slot_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] data_o
);
  logic          take;
  logic [SW-1:0] pos;
  logic          in_win;

  // slot_i counts completed rises; on the rising phase the current slot is one ahead
  generate
    if (SAMPLE_FALL) begin : g_fall
      assign take = fall_i;
      assign pos  = slot_i;
    end else begin : g_rise
      assign take = rise_i;
      assign pos  = slot_i + SW'(1);
    end
  endgenerate

  assign in_win = (pos > SW'(LEAD)) && (pos <= SW'(LEAD + DATA_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            data_o <= '0;
    else if (take && in_win) data_o <= {data_o[DATA_W-2:0], din_i};
  end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int CAL_CYCLES  = 14000,
  parameter int CONV_CYCLES = 20,
  parameter int DATA_W      = 14,
  parameter int RST_LEN     = 8,
  parameter bit CAL_BY_EOC  = 1'b0,
  parameter int SW          = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              eoc_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [DATA_W-1:0] cap_i,
  output logic              run_o,
  output logic [SW-1:0]     slot_o,
  output logic              adc_rst_no,
  output logic              cs_no,
  output logic              conv_no,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              busy_o
);
  localparam int RW = $clog2(RST_LEN + 1);
  localparam int CW = $clog2(CAL_CYCLES + 1);

  seq_st_e           st_q, st_d;
  logic [RW-1:0]     rst_cnt_q;
  logic [CW-1:0]     cal_cnt_q;
  logic [SW-1:0]     slot_q;
  logic              pend_q;
  logic [1:0]        eoc_sync_q;
  logic              cal_ok, launch, conv_end;

  generate
    if (CAL_BY_EOC) begin : g_eoc
      assign cal_ok = !eoc_sync_q[1] && (cal_cnt_q != '0);
    end else begin : g_cnt
      assign cal_ok = (cal_cnt_q == CW'(CAL_CYCLES));
    end
  endgenerate

  assign launch   = (st_q == ST_IDLE) && pend_q;
  assign conv_end = (st_q == ST_CONV) && fall_i && (slot_q == SW'(CONV_CYCLES));

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RST:  if (rst_cnt_q == RW'(RST_LEN - 1)) st_d = ST_CAL;
      ST_CAL:  if (fall_i && cal_ok)              st_d = ST_IDLE;
      ST_IDLE: if (pend_q)                        st_d = ST_CONV;
      ST_CONV: if (conv_end)                      st_d = ST_IDLE;
      default:                                    st_d = ST_RST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RST;
      rst_cnt_q  <= '0;
      cal_cnt_q  <= '0;
      slot_q     <= '0;
      pend_q     <= 1'b0;
      valid_o    <= 1'b0;
      result_o   <= '0;
      eoc_sync_q <= 2'b11;
    end else begin
      st_q       <= st_d;
      eoc_sync_q <= {eoc_sync_q[0], eoc_i};
      pend_q     <= start_i | (pend_q & ~launch);
      valid_o    <= conv_end;
      if (st_q == ST_RST) begin
        rst_cnt_q <= rst_cnt_q + RW'(1);
        cal_cnt_q <= '0;
      end
      if (st_q == ST_CAL && rise_i && cal_cnt_q != '1) cal_cnt_q <= cal_cnt_q + CW'(1);
      if (launch)                          slot_q <= '0;
      else if (st_q == ST_CONV && rise_i)  slot_q <= slot_q + SW'(1);
      if (conv_end) result_o <= cap_i;
    end
  end

  assign run_o      = (st_q == ST_CAL) || (st_q == ST_CONV);
  assign slot_o     = (st_q == ST_CONV) ? slot_q : '0;
  assign adc_rst_no = (st_q != ST_RST);
  assign cs_no      = (st_q != ST_CONV);
  assign conv_no    = (st_q != ST_CONV);
  assign busy_o     = pend_q | (st_q == ST_CONV);

  // R5
  slot_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CONV) |-> (slot_q <= SW'(CONV_CYCLES)));

  generate
    if (!CAL_BY_EOC) begin : g_cal_chk
      // R2
      cal_before_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cs_no) |-> (cal_cnt_q == CW'(CAL_CYCLES)));
    end
  endgenerate
endmodule

// File: rtl/adc_conv_reader.sv
module adc_conv_reader #(
  parameter int HALF_DIV     = 2,
  parameter int CAL_CYCLES   = 14000,
  parameter int CONV_CYCLES  = 20,
  parameter int DATA_W       = 14,
  parameter int TAIL_BITS    = 2,
  parameter int RST_LEN      = 8,
  parameter bit CAL_BY_EOC   = 1'b0,
  parameter bit SAMPLE_FALL  = 1'b0,
  parameter int MAX_CONV_CYC = 2500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              eoc_i,
  input  logic              dout_i,
  output logic              adc_rst_no,
  output logic              adc_cs_no,
  output logic              adc_conv_no,
  output logic              adc_clk_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              busy_o
);
  localparam int LEAD = CONV_CYCLES - DATA_W - TAIL_BITS;
  localparam int SW   = $clog2(CONV_CYCLES + 2);
  localparam int TW   = $clog2(MAX_CONV_CYC + 1) + 1;

  logic              run, rise, fall;
  logic [SW-1:0]     slot;
  logic [DATA_W-1:0] cap;

  adc_rd_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk_i, .rst_ni, .run_i(run), .sclk_o(adc_clk_o), .rise_o(rise), .fall_o(fall)
  );

  adc_rd_shift #(
    .DATA_W(DATA_W), .LEAD(LEAD), .SW(SW), .SAMPLE_FALL(SAMPLE_FALL)
  ) u_shift (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall), .slot_i(slot), .din_i(dout_i), .data_o(cap)
  );

  adc_rd_seq #(
    .CAL_CYCLES(CAL_CYCLES), .CONV_CYCLES(CONV_CYCLES), .DATA_W(DATA_W),
    .RST_LEN(RST_LEN), .CAL_BY_EOC(CAL_BY_EOC), .SW(SW)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .eoc_i, .rise_i(rise), .fall_i(fall), .cap_i(cap),
    .run_o(run), .slot_o(slot), .adc_rst_no, .cs_no(adc_cs_no), .conv_no(adc_conv_no),
    .result_o, .valid_o, .busy_o
  );

  // conversion-length watch for the 20 ms ceiling
  logic [TW-1:0] tmr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tmr_q <= '0;
    else if (adc_cs_no)   tmr_q <= '0;
    else if (tmr_q != '1) tmr_q <= tmr_q + TW'(1);
  end

  // R11
  conv_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_cs_no |-> (tmr_q < TW'(MAX_CONV_CYC)));
  // R1
  rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rst_no |-> (!adc_clk_o && adc_cs_no && !valid_o));
  // R8
  valid_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_cs_no) |-> valid_o);
  // R8
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R10
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> valid_o);
endmodule

// File: tb/adc_conv_reader_tb_top.sv
module adc_model (
  input  logic        sclk_i,
  input  logic        cs_ni,
  input  logic        rst_ni,
  input  logic [13:0] code_i,
  output logic        dout_o,
  output logic        eoc_o
);
  int slot = 0;
  int rises = 0;
  initial begin dout_o = 1'b1; eoc_o = 1'b1; end

  function automatic logic bit_at(int s);
    if (s >= 5 && s <= 18) return code_i[18 - s];
    return 1'b1;
  endfunction

  always @(negedge rst_ni) begin eoc_o = 1'b1; rises = 0; end
  always @(posedge sclk_i) if (rst_ni && cs_ni && eoc_o) begin
    rises++;
    if (rises == 14000) begin #1 eoc_o = 1'b0; end
  end
  always @(negedge cs_ni) begin slot = 1; dout_o = bit_at(1); end
  always @(negedge sclk_i) if (!cs_ni) begin slot++; #1 dout_o = bit_at(slot); end
endmodule

module conv_mon (
  input  logic clk_i, rst_ni, adc_rst_ni, sclk_i, cs_ni, valid_i, busy_i, eoc_i,
  output int   rst_len, cal_edges, conv_edges, cs_low_len, hi_len, valid_cnt, conv_n,
  output logic valid_wide, busy_at_valid, eoc_at_start
);
  int edge_acc = 0, low_acc = 0, hi_acc = 0, vrun = 0;
  logic sclk_p = 0, cs_p = 1, seen_cs = 0;
  initial begin
    rst_len = 0; cal_edges = 0; conv_edges = 0; cs_low_len = 0; hi_len = 0;
    valid_cnt = 0; conv_n = 0; valid_wide = 0; busy_at_valid = 0; eoc_at_start = 1;
  end
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      rst_len = 0; cal_edges = 0; seen_cs = 0; hi_acc = 0; vrun = 0;
    end else begin
      if (!adc_rst_ni) rst_len++;
      if (!cs_ni && cs_p) begin
        if (!seen_cs) eoc_at_start = eoc_i;
        seen_cs = 1; edge_acc = 0; low_acc = 0;
      end
      if (sclk_i && !sclk_p) begin
        if (!seen_cs && adc_rst_ni) cal_edges++;
        if (!cs_ni) edge_acc++;
      end
      if (sclk_i) hi_acc++;
      if (!sclk_i && sclk_p) begin hi_len = hi_acc; hi_acc = 0; end
      if (!cs_ni) low_acc++;
      if (cs_ni && !cs_p) begin conv_edges = edge_acc; cs_low_len = low_acc; conv_n++; end
      if (valid_i) begin
        vrun++;
        if (vrun == 1) begin valid_cnt++; busy_at_valid = busy_i; end
        if (vrun > 1) valid_wide = 1;
      end else vrun = 0;
    end
    sclk_p = sclk_i; cs_p = cs_ni;
  end
endmodule

module adc_conv_reader_tb_top;
  localparam int RST_LEN = 8;
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{14'h0000, 14'h3FFF, 14'h2AAA, 14'h1555, 14'h2001, 14'h1234};

  logic clk = 0, rst_n = 0, start_a = 0, start_b = 0;
  logic [13:0] code_a = 0, code_b = 0;
  logic dout_a, eoc_a, dout_b, eoc_b;
  logic arst_a, cs_a, cv_a, sclk_a, val_a, busy_a;
  logic arst_b, cs_b, cv_b, sclk_b, val_b, busy_b;
  logic [13:0] res_a, res_b;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  adc_conv_reader #(.HALF_DIV(1), .RST_LEN(RST_LEN), .CAL_BY_EOC(1'b0), .SAMPLE_FALL(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .eoc_i(eoc_a), .dout_i(dout_a),
    .adc_rst_no(arst_a), .adc_cs_no(cs_a), .adc_conv_no(cv_a), .adc_clk_o(sclk_a),
    .result_o(res_a), .valid_o(val_a), .busy_o(busy_a));
  adc_conv_reader #(.HALF_DIV(2), .RST_LEN(RST_LEN), .CAL_BY_EOC(1'b1), .SAMPLE_FALL(1'b1)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .eoc_i(eoc_b), .dout_i(dout_b),
    .adc_rst_no(arst_b), .adc_cs_no(cs_b), .adc_conv_no(cv_b), .adc_clk_o(sclk_b),
    .result_o(res_b), .valid_o(val_b), .busy_o(busy_b));

  adc_model mdl_a (.sclk_i(sclk_a), .cs_ni(cs_a), .rst_ni(arst_a), .code_i(code_a), .dout_o(dout_a), .eoc_o(eoc_a));
  adc_model mdl_b (.sclk_i(sclk_b), .cs_ni(cs_b), .rst_ni(arst_b), .code_i(code_b), .dout_o(dout_b), .eoc_o(eoc_b));

  int rl_a, ce_a, cve_a, cl_a, hl_a, vc_a, cn_a; logic vw_a, bv_a, es_a;
  int rl_b, ce_b, cve_b, cl_b, hl_b, vc_b, cn_b; logic vw_b, bv_b, es_b;
  conv_mon mon_a (.clk_i(clk), .rst_ni(rst_n), .adc_rst_ni(arst_a), .sclk_i(sclk_a), .cs_ni(cs_a),
    .valid_i(val_a), .busy_i(busy_a), .eoc_i(eoc_a), .rst_len(rl_a), .cal_edges(ce_a), .conv_edges(cve_a),
    .cs_low_len(cl_a), .hi_len(hl_a), .valid_cnt(vc_a), .conv_n(cn_a), .valid_wide(vw_a),
    .busy_at_valid(bv_a), .eoc_at_start(es_a));
  conv_mon mon_b (.clk_i(clk), .rst_ni(rst_n), .adc_rst_ni(arst_b), .sclk_i(sclk_b), .cs_ni(cs_b),
    .valid_i(val_b), .busy_i(busy_b), .eoc_i(eoc_b), .rst_len(rl_b), .cal_edges(ce_b), .conv_edges(cve_b),
    .cs_low_len(cl_b), .hi_len(hl_b), .valid_cnt(vc_b), .conv_n(cn_b), .valid_wide(vw_b),
    .busy_at_valid(bv_b), .eoc_at_start(es_b));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit a, input bit b);
    @(posedge clk); #2; start_a = a; start_b = b;
    @(posedge clk); #2; start_a = 0; start_b = 0;
  endtask

  task automatic wait_both(input int na, input int nb);
    while (vc_a < na || vc_b < nb) @(negedge clk);
  endtask

  task automatic check_reset_state();
    check(!arst_a && !arst_b, "R1 adc_rst_no low in reset", int'(arst_a), 0);
    check(cs_a && cv_a && cs_b && cv_b, "R1 cs/conv high", int'(cs_a & cv_a), 1);
    check(!sclk_a && !sclk_b, "R1 clock low", int'(sclk_a), 0);
    check(!val_a && !busy_a && !val_b && !busy_b, "R1 valid/busy low", int'(val_a | busy_a), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base_a;
    repeat (3) @(negedge clk);
    check_reset_state();
    @(posedge clk); #2; rst_n = 1;
    code_a = VEC[0]; code_b = VEC[0];
    repeat (100) @(negedge clk);
    check(rl_a == RST_LEN && rl_b == RST_LEN, "R1 converter reset length", rl_a, RST_LEN);
    // R9 request during calibration is held
    pulse(1, 1);
    @(negedge clk);
    check(busy_a && busy_b, "R10 busy after start", int'(busy_a), 1);
    check(cs_a && cs_b, "R9 no conversion during calibration", int'(cs_a), 1);
    wait_both(1, 1);
    @(negedge clk);
    check(ce_a == 14000, "R2 calibration rising edges", ce_a, 14000);
    check(es_b == 1'b0, "R3 eoc low before first conversion", int'(es_b), 0);
    check(res_a == VEC[0], "R6 result zero code, filler ignored", int'(res_a), int'(VEC[0]));
    check(res_b == VEC[0], "R7 fall-sample result", int'(res_b), int'(VEC[0]));

    // table walk
    for (int i = 1; i < NV; i++) begin
      code_a = VEC[i]; code_b = VEC[i];
      pulse(1, 1);
      @(negedge clk);
      check(busy_a && busy_b, "R10 busy after start", int'(busy_b), 1);
      wait_both(i + 1, i + 1);
      repeat (2) @(negedge clk);
      check(res_a == VEC[i], "R6 rise-sample result", int'(res_a), int'(VEC[i]));
      check(res_b == VEC[i], "R7 fall-sample result", int'(res_b), int'(VEC[i]));
      check(cve_a == 20 && cve_b == 20, "R5 clocks per conversion", cve_b, 20);
      check(cl_a == 40, "R11 cs low length HALF_DIV=1", cl_a, 40);
      check(cl_b == 80, "R11 cs low length HALF_DIV=2", cl_b, 80);
      check(!bv_a && !bv_b, "R10 busy low with valid", int'(bv_a), 0);
    end
    check(hl_a == 1 && hl_b == 2, "R4 clock high phase", hl_b, 2);
    check(!sclk_a && !sclk_b, "R4 clock rests low", int'(sclk_a), 0);
    check(!vw_a && !vw_b, "R8 valid single cycle", int'(vw_a), 0);

    // R8 result holds
    repeat (50) @(negedge clk);
    check(res_a == VEC[NV-1], "R8 result holds", int'(res_a), int'(VEC[NV-1]));

    // R9 request during a conversion
    base_a = cn_a;
    code_a = 14'h0F0F;
    pulse(1, 0);
    while (cs_a) @(negedge clk);
    repeat (10) @(negedge clk);
    pulse(1, 0);
    check(busy_a, "R9 busy held mid-conversion", int'(busy_a), 1);
    while (cn_a < base_a + 2) @(negedge clk);
    repeat (3) @(negedge clk);
    check(cn_a == base_a + 2, "R9 held request served", cn_a - base_a, 2);
    check(res_a == 14'h0F0F, "R9 second result", int'(res_a), 16'h0F0F);
    check(!busy_a, "R10 busy clear when idle", int'(busy_a), 0);

    // reset mid-run
    @(posedge clk); #2; rst_n = 0;
    repeat (3) @(negedge clk);
    check_reset_state();
    @(posedge clk); #2; rst_n = 1;
    repeat (30) @(negedge clk);
    check(rl_a == RST_LEN && rl_b == RST_LEN, "R1 converter reset length after re-reset", rl_b, RST_LEN);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule